// File: doc/BRIEF.md
# External Interrupt Edge and Level Detector

This block watches a parameterised number of external interrupt pins (two by default). Each pin has its own 2-bit trigger mode, enable bit, event flag and interrupt request. Three edge modes (falling, rising, any change) sample the pin through a clocked synchronizer. These modes work only while the I/O clock is running, which the block sees as a run qualifier on its clock. The low-level mode needs no clock. Its request follows the pin directly, so a held-low pin can request wake-up while the I/O clock is stopped. The low-level mode has no latched flag.

Stopping the I/O clock arms a hold-off on level interrupts. From then on, an enabled low level drives only the wake output. The level interrupt is held off until the start-up-done strobe arrives. If the pin is still low at the strobe, the interrupt is raised. If the level went away earlier, the system still wakes, but no interrupt follows. Software can also raise any interrupt by driving the pin itself, because the detector takes no notice of pin direction.

Top module: `ext_irq_detect`

## Requirements
- R1: With mode 2'b10 (falling), a 1-to-0 change of the pin sets that input's flag on the third rising clock edge after the change. This holds when the change occurs at least three run cycles after the I/O clock restarted.
- R2: With mode 2'b11 (rising), a 0-to-1 change sets the flag with the same latency as R1.
- R3: With mode 2'b01 (any change), both directions set the flag with the same latency as R1.
- R4: Driving flag_clr_i[i] high for one clock clears flag i. When a detected edge and a clear land on the same clock edge, the flag ends up set.
- R5: In mode 2'b00 (low level), the flag stays at 0. While the hold-off is not armed, irq_o[i] equals enable_i[i] AND NOT pin_i[i], with no clock involved.
- R6: In edge modes, irq_o[i] equals flag_o[i] AND enable_i[i]. Clearing the enable does not alter the flag.
- R7: Pin edges that happen while io_clk_run_i is low are never flagged. Neither are edges during the first three run cycles after the I/O clock restarts.
- R8: After io_clk_run_i falls, wake_o goes high without any clock edge whenever an enabled pin in mode 2'b00 is low. During that time the level interrupt of that pin stays low.
- R9: One clock edge after startup_done_i is sampled high, the level hold-off is released. A pin still low at that point then raises irq_o. A pin that returned high before the strobe raises nothing, and wake_o drops.
- R10: After reset all flags are 0. The hold-off is released and wake_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk_run_i | input | 1 | High while the I/O clock is running; low while it is stopped |
| startup_done_i | input | 1 | One-cycle strobe marking the end of oscillator start-up |
| pin_i | input | N_IN | External interrupt pins (asynchronous) |
| mode_i | input | 2*N_IN | Trigger mode per input, 2 bits each: 00 level, 01 any, 10 fall, 11 rise |
| enable_i | input | N_IN | Interrupt enable per input |
| flag_clr_i | input | N_IN | Write-one clear of each edge flag |
| flag_o | output | N_IN | Latched edge flags |
| irq_o | output | N_IN | Interrupt requests |
| wake_o | output | 1 | Asynchronous wake request from enabled low levels |

## Verification
The properties assume two things about the inputs. First, the run qualifier and the start-up strobe are driven synchronously to clk. Second, the strobe comes only after the I/O clock has stopped, and before or together with its restart. The stimulus keeps the run qualifier high through the random phase. It toggles it only in directed sequences of the order stop, start-up strobe, restart. Pins, modes, enables and clears change only at the falling clock edge. For each of them, the bench reference model predicts the flag from the pin values sampled at the rising edges.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_ANY  = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_RISE = 2'b11
   } trig_mode_e;

   function automatic logic is_level_mode(input logic [1:0] m);
      return (trig_mode_e'(m) == TRIG_LOW);
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  chain <= RST_VAL;
            else if (en) chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  chain <= {STAGES{RST_VAL}};
            else if (en) chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit
   import ext_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       edge_valid,
   input  logic       pin,
   input  logic [1:0] mode,
   input  logic       clr,
   output logic       flag
);

   logic pin_s;
   logic pin_prev;
   logic hit;

   ext_irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (run),
      .d     (pin),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pin_prev <= 1'b0;
      else if (run) pin_prev <= pin_s;
   end

   always_comb begin
      unique case (trig_mode_e'(mode))
         TRIG_ANY:  hit = pin_s ^ pin_prev;
         TRIG_FALL: hit = pin_prev & ~pin_s;
         TRIG_RISE: hit = ~pin_prev & pin_s;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flag <= 1'b0;
      else if (is_level_mode(mode))      flag <= 1'b0;
      else if (run && edge_valid && hit) flag <= 1'b1;
      else if (clr)                      flag <= 1'b0;
   end

endmodule

// File: rtl/ext_irq_wake_ctl.sv
module ext_irq_wake_ctl #(
   parameter int SETTLE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic startup_done,
   input  logic lvl_low_any,
   output logic edge_valid,
   output logic gate_open,
   output logic wake
);

   localparam int CW = $clog2(SETTLE + 1);

   logic [CW-1:0] settle_cnt;
   logic          run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         settle_cnt <= '0;
      else if (!run)                      settle_cnt <= '0;
      else if (settle_cnt != CW'(SETTLE)) settle_cnt <= settle_cnt + 1'b1;
   end

   assign edge_valid = (settle_cnt == CW'(SETTLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gate_open <= 1'b1;
      else if (startup_done)   gate_open <= 1'b1;
      else if (run_q && !run)  gate_open <= 1'b0;
   end

   assign wake = ~gate_open & lvl_low_any;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int N_IN        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_clk_run_i,
   input  logic              startup_done_i,
   input  logic [N_IN-1:0]   pin_i,
   input  logic [2*N_IN-1:0] mode_i,
   input  logic [N_IN-1:0]   enable_i,
   input  logic [N_IN-1:0]   flag_clr_i,
   output logic [N_IN-1:0]   flag_o,
   output logic [N_IN-1:0]   irq_o,
   output logic              wake_o
);

   localparam int SETTLE = SYNC_STAGES + 1;

   generate
      if (N_IN < 1) begin : g_bad_n
         $error("ext_irq_detect: N_IN must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ext_irq_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              edge_valid;
   logic              gate_open;
   logic [N_IN-1:0]   lvl_sel;
   logic [N_IN-1:0]   lvl_low;

   ext_irq_wake_ctl #(.SETTLE(SETTLE)) u_wake (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (io_clk_run_i),
      .startup_done (startup_done_i),
      .lvl_low_any  (|lvl_low),
      .edge_valid   (edge_valid),
      .gate_open    (gate_open),
      .wake         (wake_o)
   );

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      ext_irq_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (io_clk_run_i),
         .edge_valid (edge_valid),
         .pin        (pin_i[i]),
         .mode       (mode_i[2*i +: 2]),
         .clr        (flag_clr_i[i]),
         .flag       (flag_o[i])
      );

      assign lvl_sel[i] = is_level_mode(mode_i[2*i +: 2]);
      assign lvl_low[i] = lvl_sel[i] & enable_i[i] & ~pin_i[i];
      assign irq_o[i]   = lvl_sel[i] ? (lvl_low[i] & gate_open)
                                     : (flag_o[i] & enable_i[i]);
   end

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
   parameter int N_IN = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_clk_run_i,
   input logic [N_IN-1:0]   pin_i,
   input logic [2*N_IN-1:0] mode_i,
   input logic [N_IN-1:0]   enable_i,
   input logic [N_IN-1:0]   flag_o,
   input logic [N_IN-1:0]   irq_o,
   input logic              wake_o
);

   for (genvar i = 0; i < N_IN; i++) begin : g_chk
      AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i[2*i +: 2] == 2'b00) |=> !flag_o[i]); // R5

      AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         !enable_i[i] |-> !irq_o[i]); // R6

      AST_EDGE_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_o[i] && mode_i[2*i +: 2] != 2'b00) |-> flag_o[i]); // R6

      AST_STOPPED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
         !io_clk_run_i |=> !$rose(flag_o[i])); // R7

      AST_WAKE_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
         (wake_o && mode_i[2*i +: 2] == 2'b00) |-> !irq_o[i]); // R8
   end

   AST_WAKE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (pin_i != {N_IN{1'b1}})); // R8

endmodule

bind ext_irq_detect ext_irq_detect_chk #(.N_IN(N_IN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .io_clk_run_i (io_clk_run_i),
   .pin_i        (pin_i),
   .mode_i       (mode_i),
   .enable_i     (enable_i),
   .flag_o       (flag_o),
   .irq_o        (irq_o),
   .wake_o       (wake_o)
);

// File: tb/sim_ext_irq_detect.sv
`timescale 1ns/1ps
module sim_ext_irq_detect;

   localparam int N = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           run = 1'b1;
   logic           sdone = 1'b0;
   logic [N-1:0]   pin = '1;
   logic [2*N-1:0] mode = '0;
   logic [N-1:0]   en = '0;
   logic [N-1:0]   clr = '0;
   logic [N-1:0]   flag;
   logic [N-1:0]   irq;
   logic           wake;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [N-1:0] h1, h2, h3, exp_flag;

   always #2 clk = ~clk;

   ext_irq_detect #(.N_IN(N), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .io_clk_run_i(run), .startup_done_i(sdone),
      .pin_i(pin), .mode_i(mode), .enable_i(en), .flag_clr_i(clr),
      .flag_o(flag), .irq_o(irq), .wake_o(wake));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [N-1:0] exp_irq(input logic [N-1:0] f);
      logic [N-1:0] r;
      for (int b = 0; b < N; b++)
         r[b] = en[b] & ((mode[2*b +: 2] == 2'b00) ? ~pin[b] : f[b]);
      return r;
   endfunction

   function automatic string req_of(input logic [1:0] m);
      case (m)
         2'b10:   return "R1";
         2'b11:   return "R2";
         2'b01:   return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic model_step();
      for (int b = 0; b < N; b++) begin
         logic hit;
         case (mode[2*b +: 2])
            2'b01:   hit = h2[b] ^ h3[b];
            2'b10:   hit = h3[b] & ~h2[b];
            2'b11:   hit = ~h3[b] & h2[b];
            default: hit = 1'b0;
         endcase
         if (mode[2*b +: 2] == 2'b00) exp_flag[b] = 1'b0;
         else if (hit)                exp_flag[b] = 1'b1;
         else if (clr[b])             exp_flag[b] = 1'b0;
      end
      h3 = h2; h2 = h1; h1 = pin;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R10: reset state
      chk("R10 flags", 32'(flag), 0);
      chk("R10 wake", 32'(wake), 0);
      chk("R10 irq", 32'(irq), 0);

      // random phase, clock running throughout
      mode = {2'b10, 2'b10};
      tick(6);
      h1 = pin; h2 = pin; h3 = pin; exp_flag = '0;
      for (int c = 0; c < 3000; c++) begin
         for (int b = 0; b < N; b++) begin
            if ($urandom % 4 == 0)  pin[b] = ~pin[b];
            if ($urandom % 64 == 0) mode[2*b +: 2] = 2'($urandom);
            if ($urandom % 16 == 0) en[b] = ~en[b];
            clr[b] = ($urandom % 8 == 0);
         end
         @(posedge clk);
         model_step();
         @(negedge clk);
         chk({req_of(mode[1:0]), " flag"}, 32'(flag), 32'(exp_flag));
         chk("R6 irq", 32'(irq), 32'(exp_irq(exp_flag)));
      end

      // settle and clear
      clr = '0; en = '0; pin = '1; mode = {2'b00, 2'b10};
      tick(5);
      clr = '1; tick(2); clr = '0;
      chk("R4 clear", 32'(flag), 0);

      // R4: set and clear on the same edge
      pin[0] = 1'b0;
      tick(2);
      clr[0] = 1'b1;
      tick(1);
      chk("R4 set wins", 32'(flag[0]), 1);
      tick(1);
      chk("R4 cleared", 32'(flag[0]), 0);
      clr[0] = 1'b0;

      // R1 and R6: flag independent of enable
      pin[0] = 1'b1; tick(4);
      pin[0] = 1'b0; tick(4);
      chk("R1 flag", 32'(flag[0]), 1);
      chk("R6 irq masked", 32'(irq[0]), 0);
      en[0] = 1'b1; #1;
      chk("R6 irq enabled", 32'(irq[0]), 1);
      en[0] = 1'b0;
      clr[0] = 1'b1; tick(1); clr[0] = 1'b0;

      // R7: edges while stopped and right after restart are ignored
      mode[1:0] = 2'b11;
      tick(4);
      run = 1'b0; tick(2);
      pin[0] = 1'b1; tick(3);
      pin[0] = 1'b0; tick(2);
      pin[0] = 1'b1; tick(2);
      sdone = 1'b1; tick(1); sdone = 1'b0;
      run = 1'b1; tick(8);
      chk("R7 no flag", 32'(flag[0]), 0);

      // R8 and R9: level wake with level gone before strobe
      mode[3:2] = 2'b00; en[1] = 1'b1; pin[1] = 1'b1;
      tick(2);
      run = 1'b0; tick(2);
      chk("R8 idle wake", 32'(wake), 0);
      pin[1] = 1'b0; #1;
      chk("R8 wake async", 32'(wake), 1);
      chk("R8 irq held", 32'(irq[1]), 0);
      tick(3);
      pin[1] = 1'b1; #1;
      chk("R8 wake gone", 32'(wake), 0);
      tick(1);
      sdone = 1'b1; tick(1); sdone = 1'b0;
      chk("R9 no irq", 32'(irq[1]), 0);
      run = 1'b1; tick(3);
      chk("R9 still none", 32'(irq[1]), 0);

      // R9: level still low at strobe
      run = 1'b0; tick(2);
      pin[1] = 1'b0; tick(3);
      chk("R8 wake held", 32'(wake), 1);
      sdone = 1'b1; tick(1); sdone = 1'b0;
      chk("R9 irq raised", 32'(irq[1]), 1);
      chk("R9 wake drops", 32'(wake), 0);
      run = 1'b1; tick(2);
      chk("R5 level irq", 32'(irq[1]), 1);
      chk("R5 level no flag", 32'(flag[1]), 0);
      pin[1] = 1'b1; #1;
      chk("R5 level released", 32'(irq[1]), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule